// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the hardware steps a processor core takes when it enters or leaves an interrupt handler. An interrupt selector hands it a type number. The block then saves the processor state on the stack. The flags word goes first. The trap and interrupt-enable flags are cleared after that write completes. Then the code segment and the instruction pointer are saved. Next the block fetches the handler's instruction pointer and code segment from the vector table at physical address zero, and loads both registers. A return request runs the reverse sequence. It pops the instruction pointer, then the code segment, then the flags word.

The block holds the stack pointer, code segment, instruction pointer and flags registers. The rest of the core writes these through a context-load port while the block is idle and reads them on dedicated outputs. The stack segment is an input. All memory traffic goes through one 16-bit word port. On that port a request stays in place until the memory signals ready.

Top module: `isr_seq`

## Requirements
- R1: While idle, a high `req_valid` is accepted in that same cycle and `req_ack` is high for exactly that cycle. If `req_valid` and `ret_req` are high together, entry is taken and the return request is not.
- R2: Entry writes three words to the stack, each at `(ss*16 + sp') mod 2^PA_W`, where `sp'` is the stack pointer after a decrement by 2 (mod 2^16). The flags word is written first, then CS, then IP. After entry, SP is 6 lower than before.
- R3: After entry, flags bit 8 (trap) and bit 9 (interrupt enable) are zero, and every other flags bit is unchanged. The stacked flags word holds the value from before clearing.
- R4: The new IP is read from byte address `type*4` and the new CS from `type*4 + 2`. When entry finishes, `ip` and `cs` hold those two words.
- R5: A return reads IP at `ss*16 + sp`, then CS at the next higher stack slot, then flags. SP rises by 2 after each read. All four registers then equal their values from before entry.
- R6: `busy` rises in the cycle after acceptance. It stays high through every access of the sequence and falls in the cycle after the final read completes.
- R7: While `mem_en` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` are held unchanged into the next cycle.
- R8: A context load (`ld_en`) takes effect only while idle. A load pulsed while `busy` is high leaves SP, CS, IP and flags unaffected.
- R9: Stack addresses wrap modulo 2^PA_W, and SP wraps modulo 2^16, so a stack pointer of 4 pushes at offsets 2, 0 and 0xFFFE.
- R10: After reset, `busy`, `req_ack` and `mem_en` are low and SP, CS, IP and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt entry request from the selector |
| req_type | input | TYPE_W | Interrupt type number |
| req_ack | output | 1 | One-cycle pulse when entry is accepted |
| ret_req | input | 1 | Return-from-interrupt request |
| busy | output | 1 | A sequence is in progress |
| ss | input | 16 | Stack segment |
| ld_en | input | 1 | Load the context registers (idle only) |
| ld_sp | input | 16 | Stack pointer load value |
| ld_cs | input | 16 | Code segment load value |
| ld_ip | input | 16 | Instruction pointer load value |
| ld_flags | input | 16 | Flags load value |
| sp | output | 16 | Current stack pointer |
| cs | output | 16 | Current code segment |
| ip | output | 16 | Current instruction pointer |
| flags | output | 16 | Current flags word |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | PA_W | Physical byte address (even) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ready |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The bench builds the block with its default parameters, TYPE_W = 8 and PA_W = 20, so it can sweep every one of the 256 interrupt types through a full entry and return. For each type it checks the vector-table addresses and the stack contents. The flags patterns used cover all four trap/enable combinations. A stack pointer of 4 exercises SP wrap, and a segment of 0xFFFF exercises the wrap of the 20-bit physical address. The memory model inserts 0 to 2 wait cycles per access in a rotating pattern, which exercises request holding and stalls at every step of both sequences.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_F,
        S_PUSH_CS,
        S_PUSH_IP,
        S_RD_IP,
        S_RD_CS,
        S_POP_IP,
        S_POP_CS,
        S_POP_F
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] cs;
        logic [WORD_W-1:0] ip;
        logic [WORD_W-1:0] flags;
    } ctx_t;

    function automatic logic is_push(seq_state_t s);
        return (s == S_PUSH_F) || (s == S_PUSH_CS) || (s == S_PUSH_IP);
    endfunction

    function automatic logic is_pop(seq_state_t s);
        return (s == S_POP_IP) || (s == S_POP_CS) || (s == S_POP_F);
    endfunction

endpackage

// File: rtl/isr_seq_fsm.sv
module isr_seq_fsm
    import isr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       ret_req,
    input  logic       mem_ready,
    output seq_state_t state,
    output logic       accept
);

    seq_state_t nxt;

    always_comb accept = (state == S_IDLE) && req_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid)    nxt = S_PUSH_F;
                else if (ret_req) nxt = S_POP_IP;
            end
            S_PUSH_F:  if (mem_ready) nxt = S_PUSH_CS;
            S_PUSH_CS: if (mem_ready) nxt = S_PUSH_IP;
            S_PUSH_IP: if (mem_ready) nxt = S_RD_IP;
            S_RD_IP:   if (mem_ready) nxt = S_RD_CS;
            S_RD_CS:   if (mem_ready) nxt = S_IDLE;
            S_POP_IP:  if (mem_ready) nxt = S_POP_CS;
            S_POP_CS:  if (mem_ready) nxt = S_POP_F;
            S_POP_F:   if (mem_ready) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/isr_seq_dp.sv
module isr_seq_dp
    import isr_seq_pkg::*;
#(
    parameter int TYPE_W = 8,
    parameter int PA_W   = 20,
    parameter int TF_BIT = 8,
    parameter int IF_BIT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_t        state,
    input  logic              accept,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [WORD_W-1:0] ss,
    input  logic              ld_en,
    input  ctx_t              ld_ctx,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output ctx_t              ctx,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    localparam logic [WORD_W-1:0] CLR_MASK = ~((WORD_W'(1) << TF_BIT) | (WORD_W'(1) << IF_BIT));

    logic [TYPE_W-1:0] vtype;
    logic [WORD_W-1:0] tmp_ip;
    logic [WORD_W-1:0] sp_dec;
    logic [WORD_W-1:0] sp_inc;
    logic [PA_W-1:0]   seg_base;
    logic [PA_W-1:0]   vec_base;

    always_comb begin
        sp_dec   = ctx.sp - WORD_W'(2);
        sp_inc   = ctx.sp + WORD_W'(2);
        seg_base = PA_W'({ss, 4'h0});
        vec_base = PA_W'({vtype, 2'b00});
    end

    always_comb begin
        mem_en    = (state != S_IDLE);
        mem_we    = is_push(state);
        mem_wdata = '0;
        mem_addr  = '0;
        unique case (state)
            S_PUSH_F:  begin mem_wdata = ctx.flags; mem_addr = seg_base + PA_W'(sp_dec); end
            S_PUSH_CS: begin mem_wdata = ctx.cs;    mem_addr = seg_base + PA_W'(sp_dec); end
            S_PUSH_IP: begin mem_wdata = ctx.ip;    mem_addr = seg_base + PA_W'(sp_dec); end
            S_RD_IP:   mem_addr = vec_base;
            S_RD_CS:   mem_addr = vec_base + PA_W'(2);
            S_POP_IP, S_POP_CS, S_POP_F: mem_addr = seg_base + PA_W'(ctx.sp);
            default:   mem_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx    <= '0;
            vtype  <= '0;
            tmp_ip <= '0;
        end else if (state == S_IDLE) begin
            if (accept) vtype <= req_type;
            if (ld_en)  ctx   <= ld_ctx;
        end else if (mem_ready) begin
            if (is_push(state)) ctx.sp <= sp_dec;
            if (is_pop(state))  ctx.sp <= sp_inc;
            unique case (state)
                S_PUSH_F: ctx.flags <= ctx.flags & CLR_MASK;
                S_RD_IP:  tmp_ip    <= mem_rdata;
                S_RD_CS:  begin ctx.cs <= mem_rdata; ctx.ip <= tmp_ip; end
                S_POP_IP: ctx.ip    <= mem_rdata;
                S_POP_CS: ctx.cs    <= mem_rdata;
                S_POP_F:  ctx.flags <= mem_rdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/isr_seq.sv
module isr_seq
    import isr_seq_pkg::*;
#(
    parameter int TYPE_W = 8,
    parameter int PA_W   = 20,
    parameter int TF_BIT = 8,
    parameter int IF_BIT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [TYPE_W-1:0] req_type,
    output logic              req_ack,
    input  logic              ret_req,
    output logic              busy,
    input  logic [15:0]       ss,
    input  logic              ld_en,
    input  logic [15:0]       ld_sp,
    input  logic [15:0]       ld_cs,
    input  logic [15:0]       ld_ip,
    input  logic [15:0]       ld_flags,
    output logic [15:0]       sp,
    output logic [15:0]       cs,
    output logic [15:0]       ip,
    output logic [15:0]       flags,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ready
);

    seq_state_t state;
    logic       accept;
    ctx_t       ctx;
    ctx_t       ld_ctx;

    always_comb begin
        ld_ctx.sp    = ld_sp;
        ld_ctx.cs    = ld_cs;
        ld_ctx.ip    = ld_ip;
        ld_ctx.flags = ld_flags;
        sp      = ctx.sp;
        cs      = ctx.cs;
        ip      = ctx.ip;
        flags   = ctx.flags;
        req_ack = accept;
        busy    = (state != S_IDLE);
    end

    isr_seq_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ret_req   (ret_req),
        .mem_ready (mem_ready),
        .state     (state),
        .accept    (accept)
    );

    isr_seq_dp #(
        .TYPE_W (TYPE_W),
        .PA_W   (PA_W),
        .TF_BIT (TF_BIT),
        .IF_BIT (IF_BIT)
    ) dp_i (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .accept    (accept),
        .req_type  (req_type),
        .ss        (ss),
        .ld_en     (ld_en),
        .ld_ctx    (ld_ctx),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .ctx       (ctx),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/isr_seq_chk.sv
module isr_seq_chk #(
    parameter int TYPE_W = 8,
    parameter int PA_W   = 20,
    parameter int TF_BIT = 8,
    parameter int IF_BIT = 9
) (
    input logic            clk,
    input logic            rst,
    input logic            req_ack,
    input logic            busy,
    input logic [15:0]     flags,
    input logic            mem_en,
    input logic            mem_we,
    input logic [PA_W-1:0] mem_addr,
    input logic [15:0]     mem_wdata,
    input logic            mem_ready
);

    logic in_entry;

    always_ff @(posedge clk) begin
        if (rst)          in_entry <= 1'b0;
        else if (req_ack) in_entry <= 1'b1;
        else if (!busy)   in_entry <= 1'b0;
    end

    // R1: acceptance only happens while idle
    p_ack_idle_r1: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> !busy);

    // R6: busy follows acceptance
    p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> busy);

    // R7: a stalled access is held
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_ready) |=> (mem_en && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R3: vector reads happen with trap and enable already cleared
    p_flags_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (in_entry && mem_en && !mem_we) |-> (!flags[TF_BIT] && !flags[IF_BIT]));

    // R4: vector reads stay inside the table
    p_vec_range_r4: assert property (@(posedge clk) disable iff (rst)
        (in_entry && mem_en && !mem_we) |-> (mem_addr[PA_W-1:TYPE_W+2] == '0));

    // R5: return performs reads only
    p_ret_reads_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !in_entry && mem_en) |-> !mem_we);

    // R6: no memory traffic while idle
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_en);

endmodule

bind isr_seq isr_seq_chk #(
    .TYPE_W (TYPE_W),
    .PA_W   (PA_W),
    .TF_BIT (TF_BIT),
    .IF_BIT (IF_BIT)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ack   (req_ack),
    .busy      (busy),
    .flags     (flags),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/isr_seq_tb_top.sv
module isr_seq_tb_top;

    localparam int TYPE_W = 8;
    localparam int PA_W   = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [TYPE_W-1:0] req_type = '0;
    logic              req_ack;
    logic              ret_req = 1'b0;
    logic              busy;
    logic [15:0]       ss = '0;
    logic              ld_en = 1'b0;
    logic [15:0]       ld_sp = '0, ld_cs = '0, ld_ip = '0, ld_flags = '0;
    logic [15:0]       sp, cs, ip, flags;
    logic              mem_en, mem_we;
    logic [PA_W-1:0]   mem_addr;
    logic [15:0]       mem_wdata;
    logic [15:0]       mem_rdata = '0;
    logic              mem_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    isr_seq #(.TYPE_W(TYPE_W), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
        .req_ack(req_ack), .ret_req(ret_req), .busy(busy), .ss(ss),
        .ld_en(ld_en), .ld_sp(ld_sp), .ld_cs(ld_cs), .ld_ip(ld_ip), .ld_flags(ld_flags),
        .sp(sp), .cs(cs), .ip(ip), .flags(flags),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // word memory keyed by byte address, 0..2 wait cycles per access
    logic [15:0] mem [bit [PA_W-1:0]];
    logic        pend = 1'b0;
    int          wait_n = 0;
    int          acc_cnt = 0;

    function automatic logic [15:0] rd_word(bit [PA_W-1:0] a);
        if (mem.exists(a)) return mem[a];
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            pend      <= 1'b0;
        end else begin
            mem_ready <= 1'b0;
            if (mem_en && !mem_ready) begin
                if (!pend) begin
                    pend    <= 1'b1;
                    wait_n  <= acc_cnt % 3;
                    acc_cnt = acc_cnt + 1;
                end else if (wait_n == 0) begin
                    mem_ready <= 1'b1;
                    mem_rdata <= rd_word(mem_addr);
                    pend      <= 1'b0;
                    if (mem_we) mem[mem_addr] = mem_wdata;
                end else begin
                    wait_n <= wait_n - 1;
                end
            end
        end
    end

    function automatic logic [PA_W-1:0] phys(logic [15:0] seg, logic [15:0] off);
        return PA_W'((32'(seg) * 16 + 32'(off)) % (1 << PA_W));
    endfunction

    function automatic logic [15:0] ivec(int t);
        return 16'((t * 16'h0131 + 16'h0100) & 16'hFFFF);
    endfunction

    function automatic logic [15:0] cvec(int t);
        return 16'((16'hF000 - t * 16'h0023) & 16'hFFFF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic load_ctx(logic [15:0] s, logic [15:0] c, logic [15:0] i, logic [15:0] f);
        ld_en = 1'b1; ld_sp = s; ld_cs = c; ld_ip = i; ld_flags = f;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        for (int t = 0; t < (1 << TYPE_W); t++) begin
            mem[PA_W'(t * 4)]     = ivec(t);
            mem[PA_W'(t * 4 + 2)] = cvec(t);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10 busy", {31'b0, busy}, 0);
        chk("R10 ack", {31'b0, req_ack}, 0);
        chk("R10 mem_en", {31'b0, mem_en}, 0);
        chk("R10 regs", {sp, cs}, 0);
        chk("R10 regs2", {ip, flags}, 0);

        for (int t = 0; t < (1 << TYPE_W); t++) begin
            logic [15:0] s0, c0, i0, f0, fexp;
            s0 = (t % 16 == 3) ? 16'h0004 : 16'(16'h8000 - t * 2);
            ss = (t % 16 == 7) ? 16'hFFFF : 16'(t * 16'h0123);
            c0 = 16'(t * 16'h0A0B + 16'h1234);
            i0 = 16'(16'hBEEF ^ (t * 16'h0101));
            f0 = 16'((t * 16'h0135) ^ ((t % 4) << 8));
            fexp = f0 & ~16'h0300;
            load_ctx(s0, c0, i0, f0);

            // entry request (sometimes with a simultaneous return request)
            req_valid = 1'b1;
            req_type  = TYPE_W'(t);
            ret_req   = (t % 8 == 5);
            #1;
            chk("R1 ack on accept", {31'b0, req_ack}, 1);
            @(negedge clk);
            req_valid = 1'b0;
            ret_req   = 1'b0;
            chk("R1 ack single cycle", {31'b0, req_ack}, 0);
            chk("R6 busy after accept", {31'b0, busy}, 1);
            if (t % 4 == 0) begin
                // R8: load while busy must be ignored
                ld_en = 1'b1; ld_sp = 16'h1111; ld_cs = 16'h2222; ld_ip = 16'h3333; ld_flags = 16'hFFFF;
                @(negedge clk);
                ld_en = 1'b0;
            end
            wait_idle();
            chk("R6 busy falls", {31'b0, busy}, 0);
            chk("R2 R8 sp after entry", {16'b0, sp}, {16'b0, 16'(s0 - 6)});
            chk("R3 R8 flags after entry", {16'b0, flags}, {16'b0, fexp});
            chk("R4 R8 ip from vector", {16'b0, ip}, {16'b0, ivec(t)});
            chk("R4 R8 cs from vector", {16'b0, cs}, {16'b0, cvec(t)});
            chk("R2 R9 stacked flags", {16'b0, rd_word(phys(ss, 16'(s0 - 2)))}, {16'b0, f0});
            chk("R2 R9 stacked cs", {16'b0, rd_word(phys(ss, 16'(s0 - 4)))}, {16'b0, c0});
            chk("R2 R9 stacked ip", {16'b0, rd_word(phys(ss, 16'(s0 - 6)))}, {16'b0, i0});

            // return
            ret_req = 1'b1;
            #1;
            chk("R1 no ack on return", {31'b0, req_ack}, 0);
            @(negedge clk);
            ret_req = 1'b0;
            chk("R6 busy on return", {31'b0, busy}, 1);
            wait_idle();
            chk("R5 sp restored", {16'b0, sp}, {16'b0, s0});
            chk("R5 cs restored", {16'b0, cs}, {16'b0, c0});
            chk("R5 ip restored", {16'b0, ip}, {16'b0, i0});
            chk("R5 flags restored", {16'b0, flags}, {16'b0, f0});
        end

        // R8: load while idle takes effect
        load_ctx(16'h0ACE, 16'h0BAD, 16'h0CAB, 16'h0300);
        chk("R8 idle load", {sp, cs}, {16'h0ACE, 16'h0BAD});
        chk("R8 idle load2", {ip, flags}, {16'h0CAB, 16'h0300});
        finish_run();
    end

endmodule